// File: doc/BRIEF.md
# SPI Master Control and Status Register Bank

This block sits between a host and an SPI master engine. The host sees a small word-addressed register window on a single-cycle synchronous bus. Each access carries an address, write data and a write strobe, or an address and a read strobe. The bank holds the engine configuration: a soft reset for the engine, a start strobe, clock polarity and phase, word length minus one, and the clock divider. It also holds the word to shift out and a copy of the last word received. It drives the chip-select pin directly from a configuration bit, so the engine never touches chip select.

Software uses the bank as follows. It clears the soft reset and sets the mode, writes the outgoing word, raises start and then lowers it, and polls the status word until the new-data flag is set. It then reads the received word. The soft reset bit comes up set, so the engine stays idle until software releases it. The bank's own registers are reset only by the system reset input. The soft reset bit has no effect on them.

Top module: `spi_csr_bank`

## Requirements
- R1: After system reset, reads return 0x0000_0001 at offset 0x0, and 0 at offsets 0x4 and 0x8. The engine reset output is 1, and the chip-select and start outputs are 0.
- R2: The engine reset output equals bit 0 of the configuration word at offset 0x0. It takes the new value one clock after a write, and stays 1 until software writes a 0 there.
- R3: The configuration word at offset 0x0 is 16 bits wide. Bit 1 drives start, bit 2 polarity, bit 3 phase, bits 9:5 word length minus one, and bits 15:10 the divider. Each output updates one clock after the write. Written bits 31:16 are discarded and read back as 0.
- R4: The chip-select output follows bit 4 of the configuration word, one clock after the write.
- R5: A write to offset 0x4 stores all 32 bits. The stored word drives the engine transmit data and reads back unchanged.
- R6: A read at offset 0x2 returns engine busy in bit 0 and engine new-data in bit 1, with all other bits 0. Writes to offset 0x2 change nothing.
- R7: On the clock where engine new-data is high after having been low, the engine's received word is loaded into the register at offset 0x8. The register holds that value while new-data stays high and after it falls.
- R8: Writes to offset 0x8 are discarded.
- R9: Reads at any offset other than 0x0, 0x2, 0x4 and 0x8 return 0.
- R10: Read data appears on the read-data output the clock after the read strobe. The output is 0 on every clock that follows a cycle without a read strobe.
- R11: The soft reset bit does not clear or block the bank's own registers. Transmit writes and receive captures still take effect while it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| host_addr | input | 4 | Byte offset of the access |
| host_wdata | input | 32 | Write data |
| host_we | input | 1 | Write strobe, one cycle per write |
| host_re | input | 1 | Read strobe, one cycle per read |
| host_rdata | output | 32 | Registered read data |
| eng_rst | output | 1 | Soft reset to the engine, active high |
| eng_start | output | 1 | Start strobe to the engine |
| eng_cpol | output | 1 | Clock polarity to the engine |
| eng_cpha | output | 1 | Clock phase to the engine |
| eng_wlen_m1 | output | 5 | Word length minus one |
| eng_div | output | 6 | Clock divider value |
| eng_tx_data | output | 32 | Word to shift out |
| eng_busy | input | 1 | Engine busy flag |
| eng_new_data | input | 1 | Engine received-word-ready flag |
| eng_rx_data | input | 32 | Engine received word |
| spi_cs | output | 1 | Chip-select pin |

## Verification
A wrong configuration bit shows up on the matching engine output one clock after the write. It also shows up in the readback of offset 0x0 one clock after the read strobe. A receive register that loads at the wrong moment shows up in the next read of offset 0x8. The bench therefore changes the engine's received word while new-data stays high, and again after it falls, and reads the register back each time. Decode faults show up as nonzero data from unmapped or read-only offsets on the clock after the strobe. They also show up as stored values that change after writes that should have been discarded.

// File: rtl/spi_csr_pkg.sv
package spi_csr_pkg;
  // Byte offsets of the register window
  localparam int OFF_SETUP  = 'h0;
  localparam int OFF_STATUS = 'h2;
  localparam int OFF_TX     = 'h4;
  localparam int OFF_RX     = 'h8;

  // Single-bit fields at the bottom of the configuration word
  localparam int BIT_SRST   = 0;
  localparam int BIT_START  = 1;
  localparam int BIT_CPOL   = 2;
  localparam int BIT_CPHA   = 3;
  localparam int BIT_CS     = 4;
  localparam int FLAG_BITS  = 5;

  // Status word bit positions
  localparam int STAT_BUSY  = 0;
  localparam int STAT_NEW   = 1;
endpackage

// File: rtl/spi_csr_setup.sv
module spi_csr_setup
  import spi_csr_pkg::*;
#(
  parameter int WLEN_W = 5,
  parameter int DIV_W  = 6,
  localparam int SETUP_W  = FLAG_BITS + WLEN_W + DIV_W,
  localparam int WLEN_LSB = FLAG_BITS,
  localparam int DIV_LSB  = FLAG_BITS + WLEN_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [SETUP_W-1:0] wdata,
  output logic [SETUP_W-1:0] setup_q,
  output logic               eng_rst_o,
  output logic               start_o,
  output logic               cpol_o,
  output logic               cpha_o,
  output logic               cs_o,
  output logic [WLEN_W-1:0]  wlen_o,
  output logic [DIV_W-1:0]   div_o
);
  localparam logic [SETUP_W-1:0] RESET_VAL = SETUP_W'(1) << BIT_SRST;

  always_ff @(posedge clk) begin
    if (rst)        setup_q <= RESET_VAL;
    else if (wr_en) setup_q <= wdata;
  end

  assign eng_rst_o = setup_q[BIT_SRST];
  assign start_o   = setup_q[BIT_START];
  assign cpol_o    = setup_q[BIT_CPOL];
  assign cpha_o    = setup_q[BIT_CPHA];
  assign cs_o      = setup_q[BIT_CS];
  assign wlen_o    = setup_q[WLEN_LSB +: WLEN_W];
  assign div_o     = setup_q[DIV_LSB +: DIV_W];

  // R2: soft reset output takes the written bit one clock later
  a_r2_srst_follows_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> eng_rst_o == $past(wdata[BIT_SRST]));

  // R3: every field output takes its written slice one clock later
  a_r3_fields_follow_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ({div_o, wlen_o} == $past(wdata[SETUP_W-1:WLEN_LSB])) &&
              (start_o == $past(wdata[BIT_START])) &&
              (cpol_o == $past(wdata[BIT_CPOL])) &&
              (cpha_o == $past(wdata[BIT_CPHA])));

  // R3: without a write the configuration outputs do not move
  a_r3_fields_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable({div_o, wlen_o, cs_o, cpha_o, cpol_o, start_o, eng_rst_o}));

  // R4: chip select takes the written bit one clock later
  a_r4_cs_follows_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> cs_o == $past(wdata[BIT_CS]));
endmodule

// File: rtl/spi_csr_txreg.sv
module spi_csr_txreg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] tx_q
);
  always_ff @(posedge clk) begin
    if (rst)        tx_q <= '0;
    else if (wr_en) tx_q <= wdata;
  end

  // R5 / R11: a write always lands, regardless of the soft reset bit
  a_r5_tx_write_lands: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> tx_q == $past(wdata));

  a_r5_tx_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(tx_q));
endmodule

// File: rtl/spi_csr_capture.sv
module spi_csr_capture #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              new_data,
  input  logic [DATA_W-1:0] rx_data,
  output logic [DATA_W-1:0] rx_q
);
  logic nd_prev_q;
  logic nd_rise;

  assign nd_rise = new_data && !nd_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      nd_prev_q <= 1'b0;
      rx_q      <= '0;
    end else begin
      nd_prev_q <= new_data;
      if (nd_rise) rx_q <= rx_data;
    end
  end

  // R7: the received word is loaded on the first high cycle of new-data
  a_r7_load_on_rise: assert property (@(posedge clk) disable iff (rst)
    (new_data && !nd_prev_q) |=> rx_q == $past(rx_data));

  // R7 / R8: no other cycle changes the receive register
  a_r7_hold_otherwise: assert property (@(posedge clk) disable iff (rst)
    !(new_data && !nd_prev_q) |=> $stable(rx_q));
endmodule

// File: rtl/spi_csr_readmux.sv
module spi_csr_readmux
  import spi_csr_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int SETUP_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [SETUP_W-1:0] setup_q,
  input  logic [DATA_W-1:0]  tx_q,
  input  logic [DATA_W-1:0]  rx_q,
  input  logic               busy,
  input  logic               new_data,
  output logic [DATA_W-1:0]  rdata_q
);
  logic [DATA_W-1:0] sel_word;
  logic              mapped;

  always_comb begin
    sel_word = '0;
    mapped   = 1'b1;
    unique case (addr)
      ADDR_W'(OFF_SETUP):  sel_word = DATA_W'(setup_q);
      ADDR_W'(OFF_STATUS): begin
        sel_word[STAT_BUSY] = busy;
        sel_word[STAT_NEW]  = new_data;
      end
      ADDR_W'(OFF_TX):     sel_word = tx_q;
      ADDR_W'(OFF_RX):     sel_word = rx_q;
      default:             mapped   = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= mapped ? sel_word : '0;
    else            rdata_q <= '0;
  end

  // R10: no read strobe, zero on the bus next cycle
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rdata_q == '0);

  // R9: reads outside the map return zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr != ADDR_W'(OFF_SETUP) && addr != ADDR_W'(OFF_STATUS) &&
     addr != ADDR_W'(OFF_TX) && addr != ADDR_W'(OFF_RX)) |=> rdata_q == '0);

  // R6: status reads carry only the two flags
  a_r6_status_bits: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(OFF_STATUS)) |=>
      rdata_q == DATA_W'({$past(new_data), $past(busy)}));

  // R3: setup readback never carries bits above the setup width
  a_r3_setup_width: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(OFF_SETUP)) |=> (rdata_q >> SETUP_W) == '0);
endmodule

// File: rtl/spi_csr_bank.sv
module spi_csr_bank
  import spi_csr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int WLEN_W = 5,
  parameter int DIV_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_we,
  input  logic              host_re,
  output logic [DATA_W-1:0] host_rdata,
  output logic              eng_rst,
  output logic              eng_start,
  output logic              eng_cpol,
  output logic              eng_cpha,
  output logic [WLEN_W-1:0] eng_wlen_m1,
  output logic [DIV_W-1:0]  eng_div,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_busy,
  input  logic              eng_new_data,
  input  logic [DATA_W-1:0] eng_rx_data,
  output logic              spi_cs
);
  localparam int SETUP_W = FLAG_BITS + WLEN_W + DIV_W;

  logic               wr_setup;
  logic               wr_tx;
  logic [SETUP_W-1:0] setup_q;
  logic [DATA_W-1:0]  rx_q;

  // Status and receive offsets have no write path (R6, R8)
  assign wr_setup = host_we && (host_addr == ADDR_W'(OFF_SETUP));
  assign wr_tx    = host_we && (host_addr == ADDR_W'(OFF_TX));

  spi_csr_setup #(.WLEN_W(WLEN_W), .DIV_W(DIV_W)) u_setup (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_setup),
    .wdata     (host_wdata[SETUP_W-1:0]),
    .setup_q   (setup_q),
    .eng_rst_o (eng_rst),
    .start_o   (eng_start),
    .cpol_o    (eng_cpol),
    .cpha_o    (eng_cpha),
    .cs_o      (spi_cs),
    .wlen_o    (eng_wlen_m1),
    .div_o     (eng_div)
  );

  spi_csr_txreg #(.DATA_W(DATA_W)) u_tx (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_tx),
    .wdata (host_wdata),
    .tx_q  (eng_tx_data)
  );

  spi_csr_capture #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .new_data (eng_new_data),
    .rx_data  (eng_rx_data),
    .rx_q     (rx_q)
  );

  spi_csr_readmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETUP_W(SETUP_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (host_re),
    .addr     (host_addr),
    .setup_q  (setup_q),
    .tx_q     (eng_tx_data),
    .rx_q     (rx_q),
    .busy     (eng_busy),
    .new_data (eng_new_data),
    .rdata_q  (host_rdata)
  );

  // R1: the engine is held in soft reset on the first cycle after system reset
  a_r1_srst_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> eng_rst && !spi_cs && !eng_start);
endmodule

// File: tb/spi_csr_bank_tb.sv
module spi_csr_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        host_we = 1'b0;
  logic        host_re = 1'b0;
  logic [31:0] host_rdata;
  logic        eng_rst, eng_start, eng_cpol, eng_cpha, spi_cs;
  logic [4:0]  eng_wlen_m1;
  logic [5:0]  eng_div;
  logic [31:0] eng_tx_data;
  logic        eng_busy = 1'b0;
  logic        eng_new_data = 1'b0;
  logic [31:0] eng_rx_data = '0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  spi_csr_bank u_dut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_we(host_we), .host_re(host_re), .host_rdata(host_rdata),
    .eng_rst(eng_rst), .eng_start(eng_start), .eng_cpol(eng_cpol),
    .eng_cpha(eng_cpha), .eng_wlen_m1(eng_wlen_m1), .eng_div(eng_div),
    .eng_tx_data(eng_tx_data), .eng_busy(eng_busy), .eng_new_data(eng_new_data),
    .eng_rx_data(eng_rx_data), .spi_cs(spi_cs)
  );

  localparam logic [31:0] CFG = 32'hDEAD_8E1C;

  // entry: {is_read, req, addr, data, expected}
  localparam int NV = 15;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 4'd1, 4'h0, 32'h0, 32'h0000_0001},        // R1 setup default
    {1'b1, 4'd1, 4'h4, 32'h0, 32'h0},                // R1 tx default
    {1'b1, 4'd1, 4'h8, 32'h0, 32'h0},                // R1 rx default
    {1'b0, 4'd3, 4'h0, CFG, 32'h0},                  // R3 write config
    {1'b1, 4'd3, 4'h0, 32'h0, {16'h0, CFG[15:0]}},   // R3 upper bits dropped
    {1'b0, 4'd5, 4'h4, 32'hCAFE_F00D, 32'h0},        // R5 write tx
    {1'b1, 4'd5, 4'h4, 32'h0, 32'hCAFE_F00D},        // R5 readback
    {1'b0, 4'd6, 4'h2, 32'hFFFF_FFFF, 32'h0},        // R6 write status
    {1'b1, 4'd6, 4'h2, 32'h0, 32'h0},                // R6 unchanged
    {1'b0, 4'd8, 4'h8, 32'h1234_5678, 32'h0},        // R8 write rx
    {1'b1, 4'd8, 4'h8, 32'h0, 32'h0},                // R8 unchanged
    {1'b1, 4'd9, 4'h6, 32'h0, 32'h0},                // R9 hole
    {1'b1, 4'd9, 4'hC, 32'h0, 32'h0},                // R9 hole
    {1'b1, 4'd9, 4'h1, 32'h0, 32'h0},                // R9 odd offset
    {1'b1, 4'd9, 4'hF, 32'h0, 32'h0}                 // R9 top offset
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_re = 1'b1;
    @(negedge clk);
    host_re = 1'b0;
    d = host_rdata;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual cycles=%0d expected completion earlier", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset outputs
    check("R1 eng_rst", {31'b0, eng_rst}, 32'd1);
    check("R1 spi_cs", {31'b0, spi_cs}, 32'd0);
    check("R1 eng_start", {31'b0, eng_start}, 32'd0);
    check("R10 idle rdata", host_rdata, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) begin
        bus_read(VEC[i][67:64], rd);
        check($sformatf("R%0d vec %0d", VEC[i][71:68], i), rd, VEC[i][31:0]);
      end else begin
        bus_write(VEC[i][67:64], VEC[i][63:32]);
      end
    end

    // R3 field outputs decoded from CFG
    check("R2 eng_rst released", {31'b0, eng_rst}, {31'b0, CFG[0]});
    check("R3 start", {31'b0, eng_start}, {31'b0, CFG[1]});
    check("R3 cpol", {31'b0, eng_cpol}, {31'b0, CFG[2]});
    check("R3 cpha", {31'b0, eng_cpha}, {31'b0, CFG[3]});
    check("R4 cs", {31'b0, spi_cs}, {31'b0, CFG[4]});
    check("R3 wlen", {27'b0, eng_wlen_m1}, (CFG >> 5) & 32'h1F);
    check("R3 div", {26'b0, eng_div}, (CFG >> 10) & 32'h3F);
    check("R5 tx out", eng_tx_data, 32'hCAFE_F00D);

    // R10 read data lasts one cycle only
    @(negedge clk); host_addr = 4'h4; host_re = 1'b1;
    @(negedge clk); host_re = 1'b0;
    check("R10 read data", host_rdata, 32'hCAFE_F00D);
    @(negedge clk);
    check("R10 back to zero", host_rdata, 32'd0);

    // R3 start strobe raised then lowered
    bus_write(4'h0, 32'h0000_0002);
    check("R3 start set", {31'b0, eng_start}, 32'd1);
    check("R4 cs cleared", {31'b0, spi_cs}, 32'd0);
    bus_write(4'h0, 32'h0000_0010);
    check("R3 start cleared", {31'b0, eng_start}, 32'd0);
    check("R4 cs set", {31'b0, spi_cs}, 32'd1);

    // R11 soft reset set again; bank still takes writes
    bus_write(4'h0, 32'h0000_0001);
    check("R2 eng_rst set", {31'b0, eng_rst}, 32'd1);
    bus_write(4'h4, 32'h0BAD_BEEF);
    bus_read(4'h4, rd);
    check("R11 tx under soft reset", rd, 32'h0BAD_BEEF);

    // R6 live status
    @(negedge clk); eng_busy = 1'b1;
    bus_read(4'h2, rd);
    check("R6 busy only", rd, 32'h1);

    // R7 capture on rising new-data (also under soft reset, R11)
    @(negedge clk); eng_rx_data = 32'hA5A5_1234; eng_new_data = 1'b1;
    @(negedge clk); eng_rx_data = 32'h1111_1111;
    bus_read(4'h2, rd);
    check("R6 busy and new", rd, 32'h3);
    bus_read(4'h8, rd);
    check("R7 captured on rise", rd, 32'hA5A5_1234);
    @(negedge clk); eng_new_data = 1'b0; eng_busy = 1'b0; eng_rx_data = 32'h2222_2222;
    bus_read(4'h8, rd);
    check("R7 held after fall", rd, 32'hA5A5_1234);
    @(negedge clk); eng_rx_data = 32'h5A5A_9876; eng_new_data = 1'b1;
    @(negedge clk); eng_new_data = 1'b0;
    bus_read(4'h8, rd);
    check("R7 second capture", rd, 32'h5A5A_9876);
    bus_write(4'h8, 32'hFFFF_0000);
    bus_read(4'h8, rd);
    check("R8 rx write ignored", rd, 32'h5A5A_9876);

    // R1 system reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 eng_rst after reset", {31'b0, eng_rst}, 32'd1);
    bus_read(4'h0, rd);
    check("R1 setup after reset", rd, 32'h1);
    bus_read(4'h4, rd);
    check("R1 tx after reset", rd, 32'h0);
    bus_read(4'h8, rd);
    check("R1 rx after reset", rd, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule